// File: doc/BRIEF.md
# Parallel LCD Bus Timing Engine

This block runs single access cycles on an 8080-style parallel bus towards a display controller that keeps its own frame memory. It generates chip select, write strobe, read strobe and a command/data select line, drives the data lines during writes and captures them during reads. The host asks for a cycle with one of three single-clock strobes: command write, parameter/data write, or read. Every edge of every strobe falls on a tick count taken from two configuration words. A granularity input sets the tick to one clock or to two clocks.

The engine is built around a three-state machine. In ST_IDLE it waits for a strobe. A command or data strobe takes the IDLE->WRITE transition, and a read strobe takes IDLE->READ. ST_WRITE returns to idle through WRITE->IDLE once the write cycle time has elapsed. ST_READ returns through READ->IDLE once the read cycle time has elapsed. The engine samples the bus input once per read, at the access-time tick, and holds that value for the host until the next read. Strobes that arrive while a cycle runs are dropped.

Top module: `lcdbus_timing_engine`

## Requirements
- R1: After reset the engine is idle. busy_o is 0, bus_oe_o is 0 and rd_data_o is 0. CS, WE and RE are at their inactive levels. A0 is at the command level.
- R2: Edge word layout: CS-on [3:0], CS-off [9:4], WE-on [13:10], WE-off [19:14], RE-on [23:20], RE-off [29:24]. Cycle word layout: write cycle [5:0], read cycle [11:6], access time [27:22]. Bits [21:12] of the cycle word have no effect.
- R3: Inside a cycle, tick 0 starts on the clock after the strobe is accepted. CS is active for ticks t with CS-on <= t < CS-off, in both write and read cycles, and is inactive while idle.
- R4: In a write cycle, WE is active for ticks WE-on <= t < WE-off. RE stays inactive.
- R5: In a read cycle, RE is active for ticks RE-on <= t < RE-off. WE stays inactive.
- R6: busy_o is high for exactly the write cycle time (write cycles) or the read cycle time (read cycles), counted in ticks. The engine is then idle again.
- R7: With half_rate_i = 0 a tick lasts one clock. With half_rate_i = 1 it lasts two clocks.
- R8: A strobe that arrives while busy_o is high has no effect on the running cycle, on A0 or on the bus data.
- R9: If strobes arrive together, command write wins over data write, and data write wins over read.
- R10: During a write cycle bus_oe_o is 1 and bus_out_o carries wr_data_i as it was at acceptance. bus_oe_o is 0 during reads and while idle.
- R11: rd_data_o takes bus_in_i as it stands during the first clock of tick access-time of a read cycle. It then holds that value through any writes until the next read captures again.
- R12: Polarity inputs: 1 makes a strobe active high, 0 makes it active low. The A0 pin equals sel ^ ~pol_a0_i, where sel is 1 for data/read cycles and 0 for command cycles. A0 keeps its level after the cycle ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_wr_i | input | 1 | Command write strobe |
| dat_wr_i | input | 1 | Parameter/data write strobe |
| rd_req_i | input | 1 | Read request strobe |
| wr_data_i | input | DATA_W | Write data, taken when a write is accepted |
| edge_word_i | input | 32 | Edge position word |
| cycle_word_i | input | 32 | Cycle length and access time word |
| half_rate_i | input | 1 | Tick = two clocks when 1 |
| pol_cs_i | input | 1 | CS active level |
| pol_we_i | input | 1 | WE active level |
| pol_re_i | input | 1 | RE active level |
| pol_a0_i | input | 1 | A0 level selector |
| bus_in_i | input | DATA_W | Data lines from the display controller |
| rd_data_o | output | DATA_W | Last captured read value |
| busy_o | output | 1 | A cycle is running |
| bus_cs_o | output | 1 | Chip select pin |
| bus_we_o | output | 1 | Write strobe pin |
| bus_re_o | output | 1 | Read strobe pin |
| bus_a0_o | output | 1 | Command/data select pin |
| bus_out_o | output | DATA_W | Data lines towards the controller |
| bus_oe_o | output | 1 | Output enable for the data lines |

## Verification
The hardest cases to reach from the ports are two. One is a strobe that lands in the middle of a running cycle. The other is the exact clock on which a read samples the bus when ticks are two clocks long. The bench puts a strobe of a different kind on the clock right after each acceptance, then checks that the pins follow the first cycle unchanged until it ends. During every read the bench drives a new, distinct value on the bus input each clock. The captured word therefore shows exactly which clock was sampled, and the sweep repeats this over six timing sets, both tick lengths and varying polarities.

// File: rtl/lcdbus_pkg.sv
package lcdbus_pkg;
    localparam int WORD_W = 32;
    localparam int ON_W   = 4;
    localparam int OFF_W  = 6;
    localparam int N_SIG  = 3;
    localparam int SIG_CS = 0;
    localparam int SIG_WE = 1;
    localparam int SIG_RE = 2;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WRITE = 2'd1,
        ST_READ  = 2'd2
    } bus_state_t;

    typedef struct packed {
        logic [ON_W-1:0]  cs_on;
        logic [OFF_W-1:0] cs_off;
        logic [ON_W-1:0]  we_on;
        logic [OFF_W-1:0] we_off;
        logic [ON_W-1:0]  re_on;
        logic [OFF_W-1:0] re_off;
        logic [OFF_W-1:0] wr_cyc;
        logic [OFF_W-1:0] rd_cyc;
        logic [OFF_W-1:0] acc;
    } timing_t;

    function automatic timing_t unpack_timing(input logic [WORD_W-1:0] edges,
                                              input logic [WORD_W-1:0] cyc);
        timing_t t;
        t.cs_on  = edges[3:0];
        t.cs_off = edges[9:4];
        t.we_on  = edges[13:10];
        t.we_off = edges[19:14];
        t.re_on  = edges[23:20];
        t.re_off = edges[29:24];
        t.wr_cyc = cyc[5:0];
        t.rd_cyc = cyc[11:6];
        t.acc    = cyc[27:22];
        return t;
    endfunction
endpackage

// File: rtl/lcdbus_tick_gen.sv
module lcdbus_tick_gen (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic start,
    input  logic half,
    output logic tick_adv,
    output logic phase0
);
    logic ph_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              ph_q <= 1'b0;
        else if (start || !run)  ph_q <= 1'b0;
        else if (half)           ph_q <= ~ph_q;
        else                     ph_q <= 1'b0;
    end

    assign tick_adv = run && (!half || ph_q);
    assign phase0   = !ph_q;

    // R7: at half rate a tick never advances on two clocks in a row
    p_half_alternates_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (run && half && tick_adv) |=> !tick_adv);
endmodule

// File: rtl/lcdbus_window.sv
module lcdbus_window #(
    parameter int ON_W  = 4,
    parameter int CNT_W = 6
) (
    input  logic             en,
    input  logic [CNT_W-1:0] tick,
    input  logic [ON_W-1:0]  on_pos,
    input  logic [CNT_W-1:0] off_pos,
    output logic             act
);
    localparam int PAD_W = CNT_W - ON_W;
    logic [CNT_W-1:0] on_ext;
    assign on_ext = {{PAD_W{1'b0}}, on_pos};
    assign act    = en && (tick >= on_ext) && (tick < off_pos);
endmodule

// File: rtl/lcdbus_timing_engine.sv
module lcdbus_timing_engine
    import lcdbus_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_wr_i,
    input  logic              dat_wr_i,
    input  logic              rd_req_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic [31:0]       edge_word_i,
    input  logic [31:0]       cycle_word_i,
    input  logic              half_rate_i,
    input  logic              pol_cs_i,
    input  logic              pol_we_i,
    input  logic              pol_re_i,
    input  logic              pol_a0_i,
    input  logic [DATA_W-1:0] bus_in_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              busy_o,
    output logic              bus_cs_o,
    output logic              bus_we_o,
    output logic              bus_re_o,
    output logic              bus_a0_o,
    output logic [DATA_W-1:0] bus_out_o,
    output logic              bus_oe_o
);
    timing_t          tm;
    bus_state_t       state_q, state_d;
    logic [OFF_W-1:0] tick_q;
    logic [OFF_W-1:0] cyc_lim;
    logic             sel_data_q;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] rdata_q;
    logic             any_req, accept, cyc_last;
    logic             tick_adv, phase0, running;
    logic [N_SIG-1:0]          win_en, win_act;
    logic [N_SIG-1:0][ON_W-1:0]  win_on;
    logic [N_SIG-1:0][OFF_W-1:0] win_off;
    logic             unused_cfg_bits;

    assign tm              = unpack_timing(edge_word_i, cycle_word_i);
    assign unused_cfg_bits = ^{edge_word_i[31:30], cycle_word_i[31:28], cycle_word_i[21:12]};

    assign any_req  = cmd_wr_i || dat_wr_i || rd_req_i;
    assign running  = (state_q != ST_IDLE);
    assign accept   = !running && any_req;
    assign cyc_lim  = (state_q == ST_READ) ? tm.rd_cyc : tm.wr_cyc;
    assign cyc_last = tick_adv && (tick_q == cyc_lim - 1'b1);

    lcdbus_tick_gen u_tick (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (running),
        .start    (accept),
        .half     (half_rate_i),
        .tick_adv (tick_adv),
        .phase0   (phase0)
    );

    // Edge windows: chip select spans both cycle kinds, strobes one kind each
    assign win_en[SIG_CS]  = running;
    assign win_en[SIG_WE]  = (state_q == ST_WRITE);
    assign win_en[SIG_RE]  = (state_q == ST_READ);
    assign win_on[SIG_CS]  = tm.cs_on;
    assign win_on[SIG_WE]  = tm.we_on;
    assign win_on[SIG_RE]  = tm.re_on;
    assign win_off[SIG_CS] = tm.cs_off;
    assign win_off[SIG_WE] = tm.we_off;
    assign win_off[SIG_RE] = tm.re_off;

    for (genvar g = 0; g < N_SIG; g++) begin : g_win
        lcdbus_window #(.ON_W(ON_W), .CNT_W(OFF_W)) u_win (
            .en      (win_en[g]),
            .tick    (tick_q),
            .on_pos  (win_on[g]),
            .off_pos (win_off[g]),
            .act     (win_act[g])
        );
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (cmd_wr_i || dat_wr_i) state_d = ST_WRITE;
                else if (rd_req_i)        state_d = ST_READ;
            end
            ST_WRITE, ST_READ: begin
                if (cyc_last) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register and cycle bookkeeping
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            tick_q     <= '0;
            sel_data_q <= 1'b0;
            wdata_q    <= '0;
            rdata_q    <= '0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                tick_q     <= '0;
                sel_data_q <= !cmd_wr_i;
                if (cmd_wr_i || dat_wr_i) wdata_q <= wr_data_i;
            end else if (tick_adv) begin
                tick_q <= tick_q + 1'b1;
            end
            if (state_q == ST_READ && tick_q == tm.acc && phase0)
                rdata_q <= bus_in_i;
        end
    end

    // Output process
    always_comb begin
        busy_o    = running;
        bus_cs_o  = ~(win_act[SIG_CS] ^ pol_cs_i);
        bus_we_o  = ~(win_act[SIG_WE] ^ pol_we_i);
        bus_re_o  = ~(win_act[SIG_RE] ^ pol_re_i);
        bus_a0_o  = ~(sel_data_q ^ pol_a0_i);
        bus_oe_o  = (state_q == ST_WRITE);
        bus_out_o = wdata_q;
        rd_data_o = rdata_q;
    end

    // R6: each cycle starts at tick zero
    p_start_tick0_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> (tick_q == '0));
    // R8: a strobe during a cycle leaves the A0 selection untouched
    p_ignore_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (running && any_req) |=> $stable(sel_data_q));
    // R10: the data drivers only turn on after a write strobe
    p_oe_from_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_oe_o) |-> $past(cmd_wr_i || dat_wr_i));
    // R11: captured data changes only during a read cycle
    p_rd_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_READ) |=> $stable(rd_data_o));
    // R3: chip select window is closed while idle
    p_cs_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !running |-> !win_act[SIG_CS]);
    // R5: no write strobe window inside a read cycle
    p_no_we_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_READ) |-> !win_act[SIG_WE]);
endmodule

// File: tb/lcdbus_timing_engine_tb_top.sv
module lcdbus_timing_engine_tb_top;
    localparam int DW = 16;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic rst_n, cmd_wr, dat_wr, rd_req, half;
    logic pol_cs, pol_we, pol_re, pol_a0;
    logic [DW-1:0] wr_data, bus_in, rd_data, bus_out;
    logic [31:0] edge_w, cyc_w;
    logic busy, cs, we, re, a0, oe;

    lcdbus_timing_engine #(.DATA_W(DW)) dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_wr_i(cmd_wr), .dat_wr_i(dat_wr),
        .rd_req_i(rd_req), .wr_data_i(wr_data), .edge_word_i(edge_w),
        .cycle_word_i(cyc_w), .half_rate_i(half), .pol_cs_i(pol_cs),
        .pol_we_i(pol_we), .pol_re_i(pol_re), .pol_a0_i(pol_a0),
        .bus_in_i(bus_in), .rd_data_o(rd_data), .busy_o(busy),
        .bus_cs_o(cs), .bus_we_o(we), .bus_re_o(re), .bus_a0_o(a0),
        .bus_out_o(bus_out), .bus_oe_o(oe));

    int n_tests = 0, n_fail = 0;
    bit done = 0;
    int cs_on, cs_off, we_on, we_off, re_on, re_off, wr_cyc, rd_cyc, acc;
    int last_rd = 0;

    task automatic chk(string req, string what, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int pin(int act, int pol);
        return pol ? act : (act ? 0 : 1);
    endfunction

    task automatic set_cfg(int c);
        cs_on  = c % 2;
        we_on  = c;
        we_off = c + 2 + (c % 2);
        re_on  = (c + 1) % 3;
        re_off = re_on + 1 + c;
        cs_off = ((we_off > re_off) ? we_off : re_off) + c / 2;
        wr_cyc = cs_off + (c % 2);
        rd_cyc = cs_off + ((c + 1) % 2);
        acc    = re_on + 1 + (c % 2);
        if (acc > rd_cyc - 1) acc = rd_cyc - 1;
        edge_w = 32'(cs_on | (cs_off << 4) | (we_on << 10) | (we_off << 14)
                 | (re_on << 20) | (re_off << 24));
        // R2: junk in bits [21:12] must not matter
        cyc_w  = 32'(wr_cyc | (rd_cyc << 6) | (((c * 7 + 3) & 63) << 12)
                 | (acc << 22));
    endtask

    // kind: 0 command, 1 data, 2 read; multi adds lower-priority strobes (R9)
    task automatic run_access(int kind, int seed, bit multi);
        int total, t, e_cs, e_we, e_re, inwin, sel;
        logic [DW-1:0] wd;
        wd = DW'(seed * 4099 + 17);
        @(negedge clk);
        chk("R11", "rd_data held", int'(rd_data), last_rd);
        cmd_wr = (kind == 0);
        dat_wr = (kind == 1) || (multi && kind == 0);
        rd_req = (kind == 2) || (multi && kind != 2);
        wr_data = wd;
        @(posedge clk);
        total = ((kind == 2) ? rd_cyc : wr_cyc) << half;
        sel = (kind != 0) ? 1 : 0;
        for (int j = 0; j < total + 2; j++) begin
            @(negedge clk);
            cmd_wr = 0; dat_wr = 0; rd_req = 0;
            wr_data = ~wd;
            t = j >> half;
            inwin = (j < total) ? 1 : 0;
            e_cs = inwin && t >= cs_on && t < cs_off;
            e_we = inwin && kind != 2 && t >= we_on && t < we_off;
            e_re = inwin && kind == 2 && t >= re_on && t < re_off;
            chk("R6", "busy", int'(busy), inwin);
            chk("R3", "cs pin", int'(cs), pin(e_cs, pol_cs));
            chk("R4", "we pin", int'(we), pin(e_we, pol_we));
            chk("R5", "re pin", int'(re), pin(e_re, pol_re));
            chk("R12", "a0 pin", int'(a0), pol_a0 ? sel : 1 - sel);
            chk("R10", "oe", int'(oe), (inwin && kind != 2) ? 1 : 0);
            if (inwin && kind != 2) chk("R10", "bus data", int'(bus_out), int'(wd));
            bus_in = DW'(seed * 131 + j * 4369 + 5);
            // R8: stray strobe of another kind right after acceptance
            if (j == 0) begin
                cmd_wr = (kind != 0);
                rd_req = (kind == 0);
            end
        end
        if (kind == 2) begin
            last_rd = (seed * 131 + (acc << half) * 4369 + 5) & 16'hFFFF;
            chk("R11", "captured", int'(rd_data), last_rd);
        end else begin
            chk("R11", "rd_data kept", int'(rd_data), last_rd);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int p, seed;
        rst_n = 0; cmd_wr = 0; dat_wr = 0; rd_req = 0; half = 0;
        pol_cs = 0; pol_we = 0; pol_re = 0; pol_a0 = 0;
        wr_data = '0; bus_in = '0; edge_w = '0; cyc_w = '0;
        set_cfg(0);
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1: reset state with all strobes active low
        chk("R1", "busy", int'(busy), 0);
        chk("R1", "oe", int'(oe), 0);
        chk("R1", "rd_data", int'(rd_data), 0);
        chk("R1", "cs", int'(cs), 1);
        chk("R1", "we", int'(we), 1);
        chk("R1", "re", int'(re), 1);
        chk("R1", "a0 command level", int'(a0), 1);
        seed = 1;
        for (int c = 0; c < 6; c++) begin
            set_cfg(c);
            for (int h = 0; h < 2; h++) begin
                half = h[0];          // R7
                for (int k = 0; k < 3; k++) begin
                    p = (c * 5 + h * 3 + k) & 15;
                    pol_cs = p[0]; pol_we = p[1]; pol_re = p[2]; pol_a0 = p[3];
                    run_access(k, seed, c >= 3);   // R2 R9 R12
                    seed++;
                end
            end
        end
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule